// File: doc/BRIEF.md
# Integer-N Synthesizer Serial Programmer

This block loads an integer-N frequency synthesizer through a write-only serial link. A request carries an integer divide count, a divide-by-2 select bit and the static configuration fields of the synthesizer. The block splits the divide count into a prescaler pair (B, A) with N = 16·B + A. It then builds three 24-bit words and sends them: the reference word first, then the control word, then a programmable settling wait, then the N word. When the last word has gone out, it samples the lock-detect input on two cycles in a row and reports the result.

A request that cannot be programmed is refused before any transfer starts. This covers a B smaller than A, and a reference divider of zero. Software or a sequencer drives `start` for one cycle while the block is idle. It then waits for the one-cycle `done` pulse. The `opErr` flag is valid in that same cycle.

Top module: `pll_spi_loader`

## Requirements
- R1: The N word carries B = nCount[16:4] at bits 20:8 and A = nCount[3:0] at bits 5:2. It also carries divSel at bit 23, div2Sel at bit 22 and cpGain at bit 21. Bits 7 and 6 are zero and bits 1:0 are the tag 2'b10.
- R2: When B < A, the block raises done with opErr within two cycles after start. spiCsN stays high for the whole request. B equal to A is accepted.
- R3: When refDiv is zero, the request is refused in the same way as in R2 and no word is sent.
- R4: The reference word is {refFlags, refDiv, 2'b01}. refFlags occupies bits 23:16 and refDiv occupies bits 15:2.
- R5: The control word is {ctrlCfg, 2'b00}, with ctrlCfg in bits 23:2.
- R6: An accepted request sends exactly three words, in the order reference, control, N. Each word is 24 bits, sent MSB first. spiCsN stays low for the whole word and returns high between words.
- R7: From the end of the control word to the start of the N word, spiCsN stays high for at least settleCycles and at most settleCycles+2 clock cycles.
- R8: If lockDetect is high on the first sample after the N word, done rises with opErr low.
- R9: lockDetect is sampled on two consecutive cycles. If it is high only on the second sample, the result is a success. If it is low on both samples, opErr is set, even if it rises later.
- R10: spiSclk idles low while spiCsN is high. Each high phase of spiSclk lasts CLK_DIV clock cycles. spiMosi is stable while spiSclk is high, so the target samples on the rising edge.
- R11: A start pulse while busy is ignored. The words sent and the result belong to the request already running, and no further request begins afterwards.
- R12: busy is high from the cycle after an accepted start until the cycle before done. done is a one-cycle pulse and never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, honoured only when idle |
| nCount | input | 17 | Requested integer divide count N |
| div2Sel | input | 1 | Divide-by-2 flag placed in the N word |
| divSel | input | 1 | Divider select placed in the N word |
| cpGain | input | 1 | Charge-pump gain bit placed in the N word |
| refFlags | input | 8 | Upper reference-word fields (reserved, band clock, test, lock precision, anti-backlash) |
| refDiv | input | 14 | Reference divider |
| ctrlCfg | input | 22 | Control-word fields, bits 23:2 |
| settleCycles | input | 16 | Settling wait before the N word, in clock cycles |
| lockDetect | input | 1 | Lock-detect input from the synthesizer |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| opErr | output | 1 | Failure flag, valid with done |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data |
| spiCsN | output | 1 | Active-low chip select |

## Verification
Most internal faults in this block appear on the serial pins within a single word time. A wrong shift count, tag or field position changes a captured 24-bit word as soon as spiCsN rises. A wrong word index changes the word order by the second word. A wrong reject decision is visible two cycles after start, because chip select then either falls or fails to fall. Faults in the wait counter or the lock-sample sequence only appear at the end of a request, as a wrong settle gap or a wrong opErr beside done.

// File: rtl/pll_loader_pkg.sv
package pll_loader_pkg;
  localparam int WORD_W     = 24;
  localparam int NCNT_W     = 17;
  localparam int PRE_W      = 4;
  localparam int B_W        = NCNT_W - PRE_W;
  localparam int REF_DIV_W  = 14;
  localparam int REF_FLAG_W = 8;
  localparam int CTRL_CFG_W = 22;
  localparam int BIT_W      = $clog2(WORD_W);

  localparam logic [1:0] TAG_REF  = 2'b01;
  localparam logic [1:0] TAG_CTRL = 2'b00;
  localparam logic [1:0] TAG_N    = 2'b10;

  typedef enum logic [1:0] {
    WORD_REF  = 2'd0,
    WORD_CTRL = 2'd1,
    WORD_N    = 2'd2
  } wordSel_e;

  typedef struct packed {
    logic     latchCfg;
    logic     loadWord;
    wordSel_e sel;
  } dpStrobe_t;
endpackage

// File: rtl/pll_loader_dp.sv
module pll_loader_dp
  import pll_loader_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpStrobe_t             strobe,
  input  logic [NCNT_W-1:0]     nCount,
  input  logic                  div2Sel,
  input  logic                  divSel,
  input  logic                  cpGain,
  input  logic [REF_FLAG_W-1:0] refFlags,
  input  logic [REF_DIV_W-1:0]  refDiv,
  input  logic [CTRL_CFG_W-1:0] ctrlCfg,
  output logic                  reqBad,
  output logic                  wordDone,
  output logic                  spiSclk,
  output logic                  spiMosi,
  output logic                  spiCsN
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [NCNT_W-1:0]     nLat;
  logic                  div2Lat, divSelLat, cpGainLat;
  logic [REF_FLAG_W-1:0] refFlagsLat;
  logic [REF_DIV_W-1:0]  refDivLat;
  logic [CTRL_CFG_W-1:0] ctrlCfgLat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nLat        <= '0;
      div2Lat     <= 1'b0;
      divSelLat   <= 1'b0;
      cpGainLat   <= 1'b0;
      refFlagsLat <= '0;
      refDivLat   <= '0;
      ctrlCfgLat  <= '0;
    end else if (strobe.latchCfg) begin
      nLat        <= nCount;
      div2Lat     <= div2Sel;
      divSelLat   <= divSel;
      cpGainLat   <= cpGain;
      refFlagsLat <= refFlags;
      refDivLat   <= refDiv;
      ctrlCfgLat  <= ctrlCfg;
    end
  end

  // prescaler split: N = 16*B + A
  logic [B_W-1:0]   bDiv;
  logic [PRE_W-1:0] aDiv;
  assign bDiv   = nLat[NCNT_W-1:PRE_W];
  assign aDiv   = nLat[PRE_W-1:0];
  assign reqBad = (bDiv < {{(B_W-PRE_W){1'b0}}, aDiv}) || (refDivLat == '0);

  logic [WORD_W-1:0] wordMux;
  always_comb begin
    case (strobe.sel)
      WORD_REF:  wordMux = {refFlagsLat, refDivLat, TAG_REF};
      WORD_CTRL: wordMux = {ctrlCfgLat, TAG_CTRL};
      default:   wordMux = {divSelLat, div2Lat, cpGainLat, bDiv, 1'b0, 1'b0, aDiv, TAG_N};
    endcase
  end

  logic [WORD_W-1:0] shReg;
  logic [BIT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg    <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      active   <= 1'b0;
      spiSclk  <= 1'b0;
      spiCsN   <= 1'b1;
      wordDone <= 1'b0;
    end else begin
      wordDone <= 1'b0;
      if (strobe.loadWord) begin
        shReg   <= wordMux;
        bitCnt  <= BIT_W'(WORD_W - 1);
        divCnt  <= '0;
        active  <= 1'b1;
        spiSclk <= 1'b0;
        spiCsN  <= 1'b0;
      end else if (active) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!spiSclk) begin
            spiSclk <= 1'b1;
          end else begin
            spiSclk <= 1'b0;
            if (bitCnt == '0) begin
              active   <= 1'b0;
              spiCsN   <= 1'b1;
              wordDone <= 1'b1;
            end else begin
              shReg  <= {shReg[WORD_W-2:0], 1'b0};
              bitCnt <= bitCnt - 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign spiMosi = shReg[WORD_W-1];

  // R10
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spiCsN |-> !spiSclk);
  // R10
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi));
endmodule

// File: rtl/pll_loader_ctrl.sv
module pll_loader_ctrl
  import pll_loader_pkg::*;
#(
  parameter int SETTLE_W = 16,
  parameter int GAP_CYC  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                reqBad,
  input  logic                wordDone,
  input  logic                lockDetect,
  output dpStrobe_t           strobe,
  output logic                busy,
  output logic                done,
  output logic                opErr
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SEND, ST_GAP, ST_SETTLE, ST_LOCKA, ST_LOCKB, ST_FIN
  } state_e;

  state_e              state, nextState;
  wordSel_e            wordCur;
  logic [SETTLE_W-1:0] waitCnt;
  logic                errReg;

  always_comb begin
    nextState       = state;
    strobe.latchCfg = 1'b0;
    strobe.loadWord = 1'b0;
    strobe.sel      = WORD_REF;
    case (state)
      ST_IDLE: if (start) begin
        strobe.latchCfg = 1'b1;
        nextState       = ST_CHECK;
      end
      ST_CHECK: if (reqBad) nextState = ST_FIN;
        else begin
          strobe.loadWord = 1'b1;
          strobe.sel      = WORD_REF;
          nextState       = ST_SEND;
        end
      ST_SEND: if (wordDone) begin
        case (wordCur)
          WORD_REF:  nextState = ST_GAP;
          WORD_CTRL: nextState = ST_SETTLE;
          default:   nextState = ST_LOCKA;
        endcase
      end
      ST_GAP: if (waitCnt <= SETTLE_W'(1)) begin
        strobe.loadWord = 1'b1;
        strobe.sel      = WORD_CTRL;
        nextState       = ST_SEND;
      end
      ST_SETTLE: if (waitCnt <= SETTLE_W'(1)) begin
        strobe.loadWord = 1'b1;
        strobe.sel      = WORD_N;
        nextState       = ST_SEND;
      end
      ST_LOCKA: nextState = lockDetect ? ST_FIN : ST_LOCKB;
      ST_LOCKB: nextState = ST_FIN;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wordCur <= WORD_REF;
      waitCnt <= '0;
      errReg  <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.loadWord) wordCur <= strobe.sel;
      if (state == ST_SEND && wordDone)
        waitCnt <= (wordCur == WORD_REF) ? SETTLE_W'(GAP_CYC) : settleCycles;
      else if (waitCnt != '0)
        waitCnt <= waitCnt - 1'b1;
      if (state == ST_IDLE && start)        errReg <= 1'b0;
      else if (state == ST_CHECK && reqBad) errReg <= 1'b1;
      else if (state == ST_LOCKB && !lockDetect) errReg <= 1'b1;
    end
  end

  assign busy  = (state != ST_IDLE) && (state != ST_FIN);
  assign done  = (state == ST_FIN);
  assign opErr = done && errReg;

  // R6
  word_done_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wordDone |-> (state == ST_SEND));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pll_spi_loader.sv
module pll_spi_loader
  import pll_loader_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int SETTLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NCNT_W-1:0]     nCount,
  input  logic                  div2Sel,
  input  logic                  divSel,
  input  logic                  cpGain,
  input  logic [REF_FLAG_W-1:0] refFlags,
  input  logic [REF_DIV_W-1:0]  refDiv,
  input  logic [CTRL_CFG_W-1:0] ctrlCfg,
  input  logic [SETTLE_W-1:0]   settleCycles,
  input  logic                  lockDetect,
  output logic                  busy,
  output logic                  done,
  output logic                  opErr,
  output logic                  spiSclk,
  output logic                  spiMosi,
  output logic                  spiCsN
);
  dpStrobe_t strobe;
  logic      reqBad, wordDone;

  pll_loader_ctrl #(.SETTLE_W(SETTLE_W), .GAP_CYC(2 * CLK_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .settleCycles(settleCycles),
    .reqBad(reqBad), .wordDone(wordDone), .lockDetect(lockDetect),
    .strobe(strobe), .busy(busy), .done(done), .opErr(opErr)
  );

  pll_loader_dp #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .nCount(nCount),
    .div2Sel(div2Sel), .divSel(divSel), .cpGain(cpGain), .refFlags(refFlags),
    .refDiv(refDiv), .ctrlCfg(ctrlCfg), .reqBad(reqBad), .wordDone(wordDone),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsN(spiCsN)
  );

  // R2
  cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spiCsN |-> busy);
  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);
endmodule

// File: tb/tb_pll_spi_loader.sv
module tb_pll_spi_loader;
  localparam int CLK_DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [16:0] nCount = '0;
  logic        div2Sel = 1'b0, divSel = 1'b0, cpGain = 1'b0;
  logic [7:0]  refFlags = '0;
  logic [13:0] refDiv = '0;
  logic [21:0] ctrlCfg = '0;
  logic [15:0] settleCycles = '0;
  logic        lockDetect;
  logic        busy, done, opErr, spiSclk, spiMosi, spiCsN;

  pll_spi_loader #(.CLK_DIV(CLK_DIV)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int lockMode = 0;
  logic [23:0] capWords[$];
  logic [23:0] curWord = '0;
  int curBits = 0, csFalls = 0, postCnt = 0, gapCnt = 0, highRun = 0;
  logic prevCs = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge spiSclk) if (rst_n && !spiCsN) begin
    curWord = {curWord[22:0], spiMosi};
    curBits++;
  end
  always @(posedge spiCsN) if (rst_n) begin
    check(curBits == 24, "R6 bits per word", curBits, 24);
    capWords.push_back(curWord);
    curBits = 0;
  end
  always @(negedge spiCsN) if (rst_n) csFalls++;

  // per-clock reference checks and lock stimulus
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && busy) check(1'b0, "R12 done with busy", 1, 0);
      if (spiCsN && spiSclk) check(1'b0, "R10 sclk idle", 1, 0);
      if (spiSclk && prevSclk && spiMosi !== prevMosi) check(1'b0, "R10 mosi stable", spiMosi, prevMosi);
      if (spiSclk) highRun++;
      else if (prevSclk) begin
        check(highRun == CLK_DIV, "R10 high phase", highRun, CLK_DIV);
        highRun = 0;
      end
      if (capWords.size() == 2 && spiCsN && busy) gapCnt++;
      if (spiCsN && !prevCs && capWords.size() == 3) postCnt = 1;
      else if (postCnt > 0) postCnt++;
    end
    prevCs = spiCsN; prevSclk = spiSclk; prevMosi = spiMosi;
    lockDetect = (lockMode == 0) || (lockMode == 1 && postCnt >= 3) || (lockMode == 3 && postCnt >= 4);
  end

  task automatic runOp(input logic [16:0] n, input logic d2, input logic ds, input logic cg,
                       input logic [7:0] rf, input logic [13:0] rd, input logic [21:0] cc,
                       input logic [15:0] st, input int lm, input bit midStart, input string tag);
    logic [23:0] eRef, eCtrl, eN;
    bit bad, expErr, seenDone;
    int cyc;
    eRef  = {rf, rd, 2'b01};
    eCtrl = {cc, 2'b00};
    eN    = {ds, d2, cg, n[16:4], 2'b00, n[3:0], 2'b10};
    bad   = (n[16:4] < {9'd0, n[3:0]}) || (rd == 0);
    expErr = bad || (lm >= 2);
    @(negedge clk);
    capWords.delete(); csFalls = 0; postCnt = 0; gapCnt = 0; lockMode = lm;
    nCount = n; div2Sel = d2; divSel = ds; cpGain = cg; refFlags = rf; refDiv = rd;
    ctrlCfg = cc; settleCycles = st; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, {"R12 busy after start ", tag}, busy, 1);
    seenDone = 0;
    for (cyc = 1; cyc < 3000; cyc++) begin
      if (midStart && cyc == 10) begin
        nCount = 17'h1FFFF; refFlags = ~rf; start = 1'b1;
      end else start = 1'b0;
      if (done) begin seenDone = 1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    check(seenDone, {"R12 done seen ", tag}, seenDone, 1);
    check(opErr == expErr, {bad ? "R2/R3 error " : "R8/R9 error ", tag}, opErr, expErr);
    if (bad) begin
      check(cyc <= 2, {"R2 reject latency ", tag}, cyc, 2);
      check(csFalls == 0, {"R3 no cs ", tag}, csFalls, 0);
    end else begin
      check(capWords.size() == 3, {"R6 word count ", tag}, capWords.size(), 3);
      if (capWords.size() == 3) begin
        check(capWords[0] == eRef,  {"R4 ref word ", tag},  capWords[0], eRef);
        check(capWords[1] == eCtrl, {"R5 ctrl word ", tag}, capWords[1], eCtrl);
        check(capWords[2] == eN,    {"R1 n word ", tag},    capWords[2], eN);
      end
      check(gapCnt >= st && gapCnt <= st + 2, {"R7 settle gap ", tag}, gapCnt, st);
    end
    @(negedge clk);
    check(!done && !busy, {"R12 done pulse ", tag}, done, 0);
    if (midStart) begin
      repeat (20) @(negedge clk);
      check(!busy && csFalls == 3, {"R11 no extra request ", tag}, csFalls, 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && spiCsN && !spiSclk, "R12 reset state", {busy, done, spiCsN, spiSclk}, 4'b0010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    runOp(17'h01234, 1'b1, 1'b0, 1'b1, 8'hA5, 14'h1ABC, 22'h2D5A3C, 16'd5, 0, 0, "basic");
    runOp(17'd255, 1'b0, 1'b1, 1'b0, 8'h3C, 14'd1, 22'h155555, 16'd1, 1, 0, "B==A second sample");
    runOp(17'd239, 1'b0, 1'b0, 1'b0, 8'h11, 14'd7, 22'h000001, 16'd3, 0, 0, "B<A");
    runOp(17'd5, 1'b1, 1'b1, 1'b1, 8'hFF, 14'h3FFF, 22'h3FFFFF, 16'd3, 0, 0, "B=0 A=5");
    runOp(17'd0, 1'b0, 1'b0, 1'b0, 8'h00, 14'd2, 22'h0, 16'd2, 0, 0, "N=0");
    runOp(17'h10000, 1'b1, 1'b0, 1'b0, 8'h81, 14'd0, 22'h12345, 16'd2, 0, 0, "refDiv zero");
    runOp(17'd254, 1'b0, 1'b1, 1'b1, 8'h5A, 14'h2001, 22'h2AAAAA, 16'd40, 2, 0, "lock never");
    runOp(17'h1FFF0, 1'b1, 1'b1, 1'b0, 8'hC3, 14'h0F0F, 22'h0F0F0F, 16'd2, 3, 0, "lock late");
    runOp(17'h00F0E, 1'b0, 1'b0, 1'b1, 8'h69, 14'h1234, 22'h1C3A5F, 16'd6, 0, 1, "start while busy");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule